// File: doc/BRIEF.md
# GPIO Interrupt Trigger Controller

This block watches up to 32 asynchronous input pins and turns selected pin activity into interrupt requests. Every pin has its own trigger setting, chosen by three configuration bits: a mode bit (level or edge), a sense bit, and a dual-edge bit. The mode bit picks level or edge triggering. In level mode the sense bit picks the active level. In edge mode the sense bit picks the active edge. When the mode bit and the dual-edge bit are both set, either edge fires and the sense bit is ignored. Detected events are held in a pending register. Software acknowledges events by writing ones to an acknowledge register, and can write back exactly the pending word it read.

Each pin passes through a two-flop synchroniser, and a previous-sample flop supplies the edge comparison. A small warm-up state machine walks WARM_0 → WARM_1 → WARM_2 → ARMED, advancing one state per clock after reset and then staying in ARMED. Detection is blocked until ARMED, so the synchroniser's reset contents never pass for a real level or transition. In each pin, the three configuration bits decode to one of five trigger kinds: TRG_LVL_LO, TRG_LVL_HI, TRG_EDGE_FALL, TRG_EDGE_RISE and TRG_EDGE_ANY. One interrupt line is high while any pending pin is also enabled.

Registers are 32 bits wide. The bus is a select strobe with a write flag, a byte address and write data. Read data is combinational and is valid while a read is selected. A read-only revision word returns 3, which tells software that dual-edge triggering is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the configuration, enable and pending registers read 0 and `irq` is low. Pin values seen during the three warm-up clocks after reset set no pending bit, even with every pin held high under the reset-default level-low setting.
- R2: With mode bit 0 (register 0x18), a pin is level triggered. Sense bit 1 (register 0x1C) is active high and sense bit 0 is active low. The pending bit is set on every clock while the active level is present, and the dual-edge bit (register 0x24) has no effect.
- R3: With mode bit 1 and dual-edge bit 0, sense bit 1 sets pending on a rising transition and sense bit 0 on a falling one. A pin that does not change sets nothing.
- R4: With mode bit 1 and dual-edge bit 1, both transitions set pending whatever the sense bit holds.
- R5: Writing a word to the acknowledge register (0x14) clears each pending bit whose write bit is 1. Bits written 0 are unchanged. Writing back the word read from the pending register (0x0C) clears every edge-triggered event it contained.
- R6: When a new event and an acknowledge hit the same bit in the same clock, the bit stays set. A level-triggered bit whose level is still active therefore reads 1 again after acknowledge.
- R7: `irq` is the OR over all pins of (pending bit AND enable bit). The enable mask is at 0x10, and `irq` is low whenever the mask is 0.
- R8: The revision register (0x20) always reads 3, and writes to it are ignored.
- R9: Registers 0x10, 0x18, 0x1C and 0x24 read back what was written. Register 0x14 and unmapped offsets read 0. Writes to 0x0C leave the pending bits unchanged. `bus_rdata` is 0 when no read is selected.
- R10: A pin change becomes visible in the pending register on the third rising clock edge after it: two edges through the synchroniser and one into the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Asynchronous pin inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Interrupt request |

## Verification
A wrong trigger decode or a missing warm-up gate shows as a wrong pending word within three clocks of the pin change or of reset release. An acknowledge that loses the set-over-clear priority shows as a level-active bit reading 0 right after the write-back. A mask or OR fault shows on `irq` in the same cycle as the pending word it depends on. The latency bound is observed directly, by reading the pending register one cycle before the expected set edge and once more right after it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_SNS  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_REV  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DUAL = 8'h24;

    localparam logic [DATA_W-1:0] REV_VALUE = 32'd3;

    typedef enum logic [2:0] {
        TRG_LVL_LO,
        TRG_LVL_HI,
        TRG_EDGE_FALL,
        TRG_EDGE_RISE,
        TRG_EDGE_ANY
    } trig_e;

    typedef enum logic [1:0] {
        WARM_0,
        WARM_1,
        WARM_2,
        ARMED
    } warm_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] cur,
    output logic [NPIN-1:0] old
);

    logic [NPIN-1:0] stage1_q;
    logic [NPIN-1:0] stage2_q;
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pin_in;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    always_comb begin
        cur = stage2_q;
        old = prev_q;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            arm,
    input  logic [NPIN-1:0] cur,
    input  logic [NPIN-1:0] old,
    input  logic [NPIN-1:0] mode,
    input  logic [NPIN-1:0] sns,
    input  logic [NPIN-1:0] dual,
    output logic [NPIN-1:0] hit,
    output logic [NPIN-1:0] lvl_hit
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        trig_e kind;
        logic  lvl_raw;
        logic  edg_raw;

        // configuration bits -> trigger kind
        always_comb begin
            if (!mode[i]) begin
                kind = sns[i] ? TRG_LVL_HI : TRG_LVL_LO;
            end else if (dual[i]) begin
                kind = TRG_EDGE_ANY;
            end else begin
                kind = sns[i] ? TRG_EDGE_RISE : TRG_EDGE_FALL;
            end
        end

        always_comb begin
            lvl_raw = 1'b0;
            edg_raw = 1'b0;
            unique case (kind)
                TRG_LVL_LO:    lvl_raw = ~cur[i];
                TRG_LVL_HI:    lvl_raw = cur[i];
                TRG_EDGE_FALL: edg_raw = old[i] & ~cur[i];
                TRG_EDGE_RISE: edg_raw = ~old[i] & cur[i];
                TRG_EDGE_ANY:  edg_raw = old[i] ^ cur[i];
                default:       ;
            endcase
        end

        always_comb begin
            hit[i]     = arm & (lvl_raw | edg_raw);
            lvl_hit[i] = arm & lvl_raw;
        end
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NPIN-1:0]   hit,
    output logic [NPIN-1:0]   mode_q,
    output logic [NPIN-1:0]   sns_q,
    output logic [NPIN-1:0]   dual_q,
    output logic [NPIN-1:0]   en_q,
    output logic [NPIN-1:0]   pend_q,
    output logic [NPIN-1:0]   ack_vec,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_go;
    logic rd_go;

    always_comb begin
        wr_go   = bus_sel & bus_wr;
        rd_go   = bus_sel & ~bus_wr;
        ack_vec = (wr_go && bus_addr == OFS_ACK) ? bus_wdata[NPIN-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            sns_q  <= '0;
            dual_q <= '0;
            en_q   <= '0;
        end else if (wr_go) begin
            case (bus_addr)
                OFS_MASK: en_q   <= bus_wdata[NPIN-1:0];
                OFS_MODE: mode_q <= bus_wdata[NPIN-1:0];
                OFS_SNS:  sns_q  <= bus_wdata[NPIN-1:0];
                OFS_DUAL: dual_q <= bus_wdata[NPIN-1:0];
                default:  ;
            endcase
        end
    end

    // new events take priority over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_vec) | hit;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            case (bus_addr)
                OFS_PEND: bus_rdata[NPIN-1:0] = pend_q;
                OFS_MASK: bus_rdata[NPIN-1:0] = en_q;
                OFS_MODE: bus_rdata[NPIN-1:0] = mode_q;
                OFS_SNS:  bus_rdata[NPIN-1:0] = sns_q;
                OFS_DUAL: bus_rdata[NPIN-1:0] = dual_q;
                OFS_REV:  bus_rdata           = REV_VALUE;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    warm_e           st_q;
    warm_e           st_d;
    logic            armed;
    logic [NPIN-1:0] sync_cur;
    logic [NPIN-1:0] sync_old;
    logic [NPIN-1:0] mode_q;
    logic [NPIN-1:0] sns_q;
    logic [NPIN-1:0] dual_q;
    logic [NPIN-1:0] en_q;
    logic [NPIN-1:0] pend_q;
    logic [NPIN-1:0] ack_vec;
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] lvl_hit;

    // warm-up state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WARM_0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            WARM_0: st_d = WARM_1;
            WARM_1: st_d = WARM_2;
            WARM_2: st_d = ARMED;
            ARMED:  st_d = ARMED;
        endcase
    end

    // state outputs
    always_comb begin
        armed = (st_q == ARMED);
    end

    gpio_irq_sync #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .cur    (sync_cur),
        .old    (sync_old)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_detect (
        .arm     (armed),
        .cur     (sync_cur),
        .old     (sync_old),
        .mode    (mode_q),
        .sns     (sns_q),
        .dual    (dual_q),
        .hit     (hit),
        .lvl_hit (lvl_hit)
    );

    gpio_irq_regs #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit       (hit),
        .mode_q    (mode_q),
        .sns_q     (sns_q),
        .dual_q    (dual_q),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .ack_vec   (ack_vec),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        irq = |(pend_q & en_q);
    end

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              armed,
    input logic [NPIN-1:0]   pend,
    input logic [NPIN-1:0]   en,
    input logic [NPIN-1:0]   mode,
    input logic [NPIN-1:0]   cur,
    input logic [NPIN-1:0]   old,
    input logic [NPIN-1:0]   ack_vec,
    input logic [NPIN-1:0]   lvl_hit
);

    AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (pend == '0)); // R1

    AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & $past(mode) & ~($past(cur) ^ $past(old))) == '0)); // R3

    AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pend & $past(pend) & ~$past(ack_vec)) == '0)); // R5

    AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(lvl_hit) & ~pend) == '0)); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq); // R7

    AST_REV_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_REV) |-> (bus_rdata == REV_VALUE)); // R8

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0)); // R9

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .armed     (armed),
    .pend      (pend_q),
    .en        (en_q),
    .mode      (mode_q),
    .cur       (sync_cur),
    .old       (sync_old),
    .ack_vec   (ack_vec),
    .lvl_hit   (lvl_hit)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    localparam logic [7:0] A_PEND = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h10;
    localparam logic [7:0] A_ACK  = 8'h14;
    localparam logic [7:0] A_MODE = 8'h18;
    localparam logic [7:0] A_SNS  = 8'h1C;
    localparam logic [7:0] A_REV  = 8'h20;
    localparam logic [7:0] A_DUAL = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] lvl_model(input logic [31:0] md, input logic [31:0] sn,
                                              input logic [31:0] p);
        return ~md & ((sn & p) | (~sn & ~p));
    endfunction

    function automatic logic [31:0] edge_model(input logic [31:0] md, input logic [31:0] sn,
                                               input logic [31:0] du, input logic [31:0] a,
                                               input logic [31:0] b);
        logic [31:0] one_way;
        one_way = (sn & ~a & b) | (~sn & a & ~b);
        return md & ((du & (a ^ b)) | (~du & one_way));
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run_case(input logic [31:0] md, input logic [31:0] sn, input logic [31:0] du,
                            input logic [31:0] en, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] rd;
        logic [31:0] exp;
        bus_write(A_MASK, en);
        bus_write(A_MODE, md);
        bus_write(A_SNS, sn);
        bus_write(A_DUAL, du);
        pin_in = a;
        repeat (5) @(negedge clk);
        bus_write(A_ACK, '1);
        pin_in = b;
        repeat (5) @(negedge clk);
        exp = lvl_model(md, sn, a) | lvl_model(md, sn, b) | edge_model(md, sn, du, a, b);
        bus_read(A_PEND, rd);
        check("R2/R3/R4 pending after pin change", rd, exp);
        check("R7 irq from pending and mask", {31'd0, irq}, {31'd0, |(exp & en)});
        bus_write(A_ACK, '0);
        bus_read(A_PEND, rd);
        check("R5 zero acknowledge keeps pending", rd, exp);
        bus_write(A_ACK, rd);
        repeat (3) @(negedge clk);
        bus_read(A_PEND, rd);
        check("R5/R6 write-back acknowledge", rd, lvl_model(md, sn, b));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h5eed_1234));

        // R1: reset with all pins high, default level-low everywhere
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(A_PEND, rd);  check("R1 pending after reset", rd, 32'h0);
        bus_read(A_MODE, rd);  check("R1 mode after reset", rd, 32'h0);
        bus_read(A_SNS, rd);   check("R1 sense after reset", rd, 32'h0);
        bus_read(A_DUAL, rd);  check("R1 dual after reset", rd, 32'h0);
        bus_read(A_MASK, rd);  check("R1 mask after reset", rd, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'h0);

        // R8: revision word
        bus_read(A_REV, rd);   check("R8 revision", rd, 32'd3);
        bus_write(A_REV, 32'hFFFF_0000);
        bus_read(A_REV, rd);   check("R8 revision after write", rd, 32'd3);

        // R9: register map
        bus_write(A_MODE, 32'hA5A5_0F0F); bus_read(A_MODE, rd); check("R9 mode readback", rd, 32'hA5A5_0F0F);
        bus_write(A_SNS, 32'h1234_5678);  bus_read(A_SNS, rd);  check("R9 sense readback", rd, 32'h1234_5678);
        bus_write(A_DUAL, 32'hCAFE_0001); bus_read(A_DUAL, rd); check("R9 dual readback", rd, 32'hCAFE_0001);
        bus_write(A_MASK, 32'h0000_FFFF); bus_read(A_MASK, rd); check("R9 mask readback", rd, 32'h0000_FFFF);
        bus_read(A_ACK, rd);   check("R9 acknowledge reads zero", rd, 32'h0);
        bus_read(8'h28, rd);   check("R9 unmapped reads zero", rd, 32'h0);
        bus_write(A_MODE, '1);
        bus_write(A_DUAL, '0);
        bus_write(A_MASK, '0);
        repeat (4) @(negedge clk);
        bus_write(A_ACK, '1);
        bus_write(A_PEND, '1);
        bus_read(A_PEND, rd);  check("R9 pending not writable", rd, 32'h0);

        // R10: latency of a rising edge on pin 0
        bus_write(A_SNS, '1);
        pin_in = 32'hFFFF_FFFE;
        repeat (5) @(negedge clk);
        bus_write(A_ACK, '1);
        pin_in = '1;
        repeat (2) @(negedge clk);
        bus_read(A_PEND, rd);  check("R10 pending before third edge", rd, 32'h0);
        bus_read(A_PEND, rd);  check("R10 pending after third edge", rd, 32'h1);
        bus_write(A_ACK, '1);

        // R6: acknowledge against an active high level
        bus_write(A_MODE, '0);
        bus_write(A_SNS, 32'h0000_0010);
        pin_in = 32'h0000_0010;
        repeat (5) @(negedge clk);
        bus_write(A_ACK, 32'h0000_0010);
        bus_read(A_PEND, rd);  check("R6 level bit survives acknowledge", rd & 32'h10, 32'h10);

        // directed trigger cases
        run_case(32'h0, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h00FF_00FF); // R2 dual ignored
        run_case('1, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF);          // R3 rising
        run_case('1, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000);          // R3 falling
        run_case('1, 32'hF0F0_F0F0, 32'hFFFF_0000, 32'h0, 32'hAAAA_AAAA, 32'h5555_5555);        // R4 any edge, R7 masked
        run_case('1, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1357_9BDF, 32'h1357_9BDF);                // R3 no change

        // constrained random
        for (int i = 0; i < 60; i++) begin
            logic [31:0] md, sn, du, en, a, b;
            md = $urandom; sn = $urandom; du = $urandom;
            en = (i % 4 == 0) ? 32'h0 : $urandom;
            a  = $urandom;
            b  = (i % 3 == 0) ? (a ^ (32'h1 << (i % 32))) : $urandom;
            run_case(md, sn, du, en, a, b);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule